// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block lets a host reach the registers of external Ethernet PHYs over a two-wire management bus. Software writes one 32-bit command word into the command register. That word holds the operation, the PHY address, the register address and, for writes, the data. The controller then builds a 64-bit management frame and shifts it out on the MDIO line. The clock for that line is derived from the system clock through a divider that software can program.

For a read, the controller releases the data line after the address fields and samples the PHY's answer. Software gets that answer by reading the command register back. Every accepted command ends with a one-cycle completion pulse on `mgmt_done`. That pulse feeds one bit of an event register owned by a neighbouring block. A command with an unknown opcode sends no frame and still completes. The host side is a plain single-cycle register port with a combinational read path and no back-pressure. A write that arrives while a frame is in flight is dropped. Software is expected to wait for the completion pulse before it writes again.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, `mdc`, `mdio_oe` and `mgmt_done` are low. The command register (offset 0x040) reads 0. The divider register (offset 0x044) reads the reset value `DIV_RST` (default 1).
- R2: A command word with opcode field [29:28] equal to 01 (write) or 10 (read) starts a frame. The other fields are PHY address [27:23], register address [22:18] and write data [15:0]. The frame starts with 32 ones and the start pattern 01, followed by the opcode, the PHY address and the register address, each sent MSB first.
- R3: In a write frame the controller drives the turnaround as 1 then 0, then the 16 data bits MSB first. It keeps `mdio_oe` high for the whole frame.
- R4: In a read frame `mdio_oe` is low from the first turnaround bit (bit 46 of the frame) through the last data bit. The 16 data bits are sampled on rising `mdc` edges, MSB first. From the completion cycle on, reading offset 0x040 returns them in bits [15:0] with bits [31:16] zero.
- R5: A read from a PHY address where no device answers returns 0xFFFF, because the line is pulled high.
- R6: Bits of the divider value written at offset 0x044 read back unchanged. The `mdc` period is 2×(divider+1) system clocks, and `mdc` stays low while no frame is running.
- R7: `mgmt_done` is high for exactly one cycle per command. For a frame, this is the cycle in which `mdc` has just fallen after its 64th rising edge.
- R8: Opcodes 00 and 11 send no frame, produce no `mdc` edge and leave the read data unchanged. `mgmt_done` is high in the cycle after the write.
- R9: Command and divider writes that arrive while a frame is in flight are ignored. The running frame, the PHY and the divider readback are all unaffected.
- R10: Every frame has exactly 64 rising `mdc` edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Register write strobe, one cycle per write |
| host_addr | input | ADDR_W | Register byte offset |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data for `host_addr` (combinational) |
| mgmt_done | output | 1 | One-cycle completion pulse |
| mdc | output | 1 | Management bus clock |
| mdio_out | output | 1 | Data driven onto the management line |
| mdio_oe | output | 1 | Output enable for `mdio_out` |
| mdio_in | input | 1 | Level sensed on the management line |

## Verification
A frame's completion and the host's next command write can fall in the same cycle. The pulse on `mgmt_done` is raised in the same edge that frees the engine, so a command written during the completion cycle must be accepted. A command written one cycle earlier must be dropped. The bench provokes this by issuing each follow-up command from inside the completion cycle. It then judges the result at the MDIO pins: a complete, correctly formed second frame must appear, and the scoreboard must pop exactly one completion per issued command. A separate test writes in the middle of a frame and expects neither a second frame nor a change in the divider.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  typedef enum logic [1:0] {
    OP_NOP0  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_NOP3  = 2'b11
  } mgmt_op_e;

  typedef struct packed {
    mgmt_op_e    op;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [15:0] wdata;
  } mgmt_cmd_t;

  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int DATA_BITS  = 16;
  localparam int TA_POS     = FRAME_BITS - DATA_BITS - 2;
  localparam int DATA_POS   = FRAME_BITS - DATA_BITS;

  function automatic mgmt_cmd_t decode_cmd(input logic [31:0] w);
    mgmt_cmd_t c;
    c.op    = mgmt_op_e'(w[29:28]);
    c.phy   = w[27:23];
    c.regad = w[22:18];
    c.wdata = w[15:0];
    return c;
  endfunction

  function automatic logic [FRAME_BITS-1:0] build_frame(input mgmt_cmd_t c);
    logic [DATA_BITS-1:0] payload;
    payload = (c.op == OP_READ) ? {DATA_BITS{1'b1}} : c.wdata;
    return {{PRE_BITS{1'b1}}, 2'b01, c.op, c.phy, c.regad, 2'b10, payload};
  endfunction

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_evt,
  output logic             fall_evt
);

  logic [DIV_W-1:0] cnt_q;
  logic             mdc_q;
  logic             tick;

  assign tick     = run && (cnt_q == div);
  assign rise_evt = tick && !mdc_q;
  assign fall_evt = tick && mdc_q;
  assign mdc      = mdc_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  mgmt_cmd_t   cmd,
  input  logic        rise_evt,
  input  logic        fall_evt,
  input  logic        mdio_in,
  output logic        busy,
  output logic        done,
  output logic        mdio_out,
  output logic        mdio_oe,
  output logic [15:0] rd_data,
  output mgmt_op_e    act_op
);

  localparam int POS_W = $clog2(FRAME_BITS);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);
  localparam logic [POS_W-1:0] TA_P     = POS_W'(TA_POS);
  localparam logic [POS_W-1:0] DATA_P   = POS_W'(DATA_POS);

  logic [FRAME_BITS-1:0] sr_q;
  logic [POS_W-1:0]      pos_q;
  logic                  busy_q;
  logic                  done_q;
  mgmt_op_e              op_q;
  logic [DATA_BITS-1:0]  rsh_q;
  logic [DATA_BITS-1:0]  rdat_q;
  logic                  is_rd;

  assign is_rd    = (op_q == OP_READ);
  assign busy     = busy_q;
  assign done     = done_q;
  assign mdio_out = sr_q[FRAME_BITS-1];
  assign mdio_oe  = busy_q && !(is_rd && (pos_q >= TA_P));
  assign rd_data  = rdat_q;
  assign act_op   = op_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q   <= '0;
      pos_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      op_q   <= OP_NOP0;
      rsh_q  <= '0;
      rdat_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start && !busy_q) begin
        busy_q <= 1'b1;
        op_q   <= cmd.op;
        sr_q   <= build_frame(cmd);
        pos_q  <= '0;
        rsh_q  <= '0;
      end else if (busy_q) begin
        if (rise_evt && is_rd && (pos_q >= DATA_P))
          rsh_q <= {rsh_q[DATA_BITS-2:0], mdio_in};
        if (fall_evt) begin
          if (pos_q == LAST_POS) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            if (is_rd) rdat_q <= rsh_q;
          end else begin
            pos_q <= pos_q + 1'b1;
            sr_q  <= {sr_q[FRAME_BITS-2:0], 1'b1};
          end
        end
      end
    end
  end

endmodule

// File: rtl/mdio_host_regs.sv
module mdio_host_regs
  import mdio_mgmt_pkg::*;
#(
  parameter int          ADDR_W  = 12,
  parameter int          DIV_W   = 8,
  parameter int unsigned CMD_OFS = 'h40,
  parameter int unsigned DIV_OFS = 'h44,
  parameter int unsigned DIV_RST = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  input  logic              busy,
  input  logic [15:0]       rd_data,
  output logic              start,
  output mgmt_cmd_t         cmd,
  output logic [DIV_W-1:0]  div,
  output logic              nop_done
);

  logic             cmd_sel, div_sel, cmd_hit, op_ok;
  logic [DIV_W-1:0] div_q;
  logic             nop_q;
  logic             unused_wbits;

  assign cmd_sel  = (host_addr == ADDR_W'(CMD_OFS));
  assign div_sel  = (host_addr == ADDR_W'(DIV_OFS));
  assign cmd      = decode_cmd(host_wdata);
  assign cmd_hit  = host_wr && cmd_sel && !busy;
  assign op_ok    = (cmd.op == OP_WRITE) || (cmd.op == OP_READ);
  assign start    = cmd_hit && op_ok;
  assign div      = div_q;
  assign nop_done = nop_q;
  assign unused_wbits = ^{host_wdata[31:30], host_wdata[17:16]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= DIV_W'(DIV_RST);
      nop_q <= 1'b0;
    end else begin
      nop_q <= cmd_hit && !op_ok;
      if (host_wr && div_sel && !busy) div_q <= host_wdata[DIV_W-1:0];
    end
  end

  always_comb begin
    host_rdata = '0;
    if (cmd_sel)      host_rdata = {16'h0000, rd_data};
    else if (div_sel) host_rdata = {{(32-DIV_W){1'b0}}, div_q};
  end

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int          ADDR_W  = 12,
  parameter int          DIV_W   = 8,
  parameter int unsigned CMD_OFS = 'h40,
  parameter int unsigned DIV_OFS = 'h44,
  parameter int unsigned DIV_RST = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              mgmt_done,
  output logic              mdc,
  output logic              mdio_out,
  output logic              mdio_oe,
  input  logic              mdio_in
);

  logic             busy;
  logic             start;
  mgmt_cmd_t        cmd;
  logic [DIV_W-1:0] div_q;
  logic             nop_done, frame_done;
  logic             rise_evt, fall_evt;
  logic [15:0]      rd_data;
  mgmt_op_e         act_op;

  mdio_host_regs #(
    .ADDR_W(ADDR_W), .DIV_W(DIV_W), .CMD_OFS(CMD_OFS),
    .DIV_OFS(DIV_OFS), .DIV_RST(DIV_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy),
    .rd_data(rd_data), .start(start), .cmd(cmd), .div(div_q),
    .nop_done(nop_done)
  );

  mdio_clk_div #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy), .div(div_q),
    .mdc(mdc), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  mdio_frame_engine u_frame (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd),
    .rise_evt(rise_evt), .fall_evt(fall_evt), .mdio_in(mdio_in),
    .busy(busy), .done(frame_done), .mdio_out(mdio_out),
    .mdio_oe(mdio_oe), .rd_data(rd_data), .act_op(act_op)
  );

  assign mgmt_done = frame_done | nop_done;

endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk
  import mdio_mgmt_pkg::*;
#(
  parameter int          ADDR_W  = 12,
  parameter int          DIV_W   = 8,
  parameter int unsigned CMD_OFS = 'h40,
  parameter int unsigned DIV_OFS = 'h44
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr,
  input logic [ADDR_W-1:0] host_addr,
  input logic              mgmt_done,
  input logic              mdc,
  input logic              mdio_oe,
  input logic              busy,
  input logic [DIV_W-1:0]  div_q,
  input mgmt_op_e          act_op
);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_done && !(host_wr && host_addr == ADDR_W'(CMD_OFS))) |=> !mgmt_done); // R7

  AST_DONE_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_done |-> !mdc); // R7

  AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !mdc); // R6

  AST_OE_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> $past(host_wr)); // R2

  AST_DIV_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_wr && host_addr == ADDR_W'(DIV_OFS)) |=> $stable(div_q)); // R9

  AST_OP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(act_op)); // R9

endmodule

bind mdio_mgmt_ctrl mdio_mgmt_chk #(
  .ADDR_W(ADDR_W), .DIV_W(DIV_W), .CMD_OFS(CMD_OFS), .DIV_OFS(DIV_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
  .mgmt_done(mgmt_done), .mdc(mdc), .mdio_oe(mdio_oe), .busy(busy),
  .div_q(div_q), .act_op(act_op)
);

// File: tb/mdio_mgmt_ctrl_test.sv
module mdio_mgmt_ctrl_test;

  localparam int ADDR_W = 12;
  localparam logic [11:0] CMD_A = 12'h040;
  localparam logic [11:0] DIV_A = 12'h044;
  localparam logic [4:0]  PHY_ID = 5'd3;

  typedef struct {
    logic [1:0]  op;
    logic [4:0]  phy;
    logic [4:0]  rg;
    logic [15:0] data;
    int          period;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic              host_wr = 1'b0;
  logic [ADDR_W-1:0] host_addr = '0;
  logic [31:0]       host_wdata = '0;
  wire  [31:0]       host_rdata;
  wire               mgmt_done, mdc, mdio_out, mdio_oe;
  logic              phy_drv = 1'b1;
  wire               mdio_in = phy_drv;

  mdio_mgmt_ctrl uut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .mgmt_done(mgmt_done),
    .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cur_div = 1;
  item_t expq[$];
  logic [15:0] phy_mem [32];
  logic [15:0] exp_mem [32];

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // PHY model: collects the frame, answers reads from its own memory
  logic [63:0] obs_bits = '0;
  logic [63:0] obs_oe = '0;
  logic [5:0]  rcnt = '0;
  int          rise_total = 0;
  time         last_rise = 0;
  bit          per_bad = 1'b0;

  always @(posedge mdc) begin
    if (rcnt == 0) per_bad = 1'b0;
    else if (expq.size() > 0 && ($time - last_rise) != expq[0].period) per_bad = 1'b1;
    last_rise = $time;
    obs_bits[63 - rcnt] = mdio_oe ? mdio_out : mdio_in;
    obs_oe[63 - rcnt]   = mdio_oe;
    if (rcnt == 63 && obs_bits[29:28] == 2'b01 && obs_bits[27:23] == PHY_ID)
      phy_mem[obs_bits[22:18]] = obs_bits[15:0];
    rise_total++;
    rcnt++;
  end

  always @(negedge mdc) begin
    if (rcnt >= 47 && obs_bits[29:28] == 2'b10 && obs_bits[27:23] == PHY_ID)
      phy_drv <= (rcnt == 47) ? 1'b0 : phy_mem[obs_bits[22:18]][15 - (rcnt - 48)];
    else
      phy_drv <= 1'b1;
  end

  // Monitor: pops one expected item per completion and judges the frame
  int   last_total = 0;
  logic prev_mdc = 1'b0;
  always @(negedge clk) begin
    if (rst_n && mgmt_done) begin
      if (expq.size() == 0) begin
        check("R9", 32'd1, 32'd0, "completion without an accepted command");
      end else begin
        item_t it;
        it = expq.pop_front();
        if (it.op == 2'b01 || it.op == 2'b10) begin
          check("R10", rise_total - last_total, 64, "rising MDC edges in frame");
          check("R2", obs_bits[63:32], 32'hFFFF_FFFF, "preamble");
          check("R2", {30'd0, obs_bits[31:30]}, 32'd1, "start pattern");
          check("R2", {30'd0, obs_bits[29:28]}, {30'd0, it.op}, "opcode");
          check("R2", {27'd0, obs_bits[27:23]}, {27'd0, it.phy}, "phy address");
          check("R2", {27'd0, obs_bits[22:18]}, {27'd0, it.rg}, "register address");
          check("R6", {31'd0, per_bad}, 32'd0, "MDC period");
          check("R7", {30'd0, prev_mdc, mdc}, 32'd2, "done on MDC fall");
          if (it.op == 2'b01) begin
            check("R3", {30'd0, obs_bits[17:16]}, 32'd2, "write turnaround");
            check("R3", {16'd0, obs_bits[15:0]}, {16'd0, it.data}, "write data");
            check("R3", obs_oe[63:32], 32'hFFFF_FFFF, "oe high (upper)");
            check("R3", obs_oe[31:0], 32'hFFFF_FFFF, "oe high (lower)");
          end else begin
            check("R4", obs_oe[63:32], 32'hFFFF_FFFF, "oe high before turnaround");
            check("R4", obs_oe[31:0], 32'hFFFC_0000, "oe released from turnaround");
          end
        end else begin
          check("R8", rise_total - last_total, 0, "no MDC edges for unknown opcode");
        end
      end
      last_total = rise_total;
    end
    prev_mdc = mdc;
  end

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic issue(input logic [1:0] op, input logic [4:0] phy,
                       input logic [4:0] rg, input logic [15:0] d);
    item_t it;
    it.op = op; it.phy = phy; it.rg = rg; it.data = d;
    it.period = 2 * (cur_div + 1) * 8;
    expq.push_back(it);
    if (op == 2'b01 && phy == PHY_ID) exp_mem[rg] = d;
    bus_write(CMD_A, {2'b00, op, phy, rg, 2'b00, d});
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!mgmt_done);
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp,
                        input string req, input string what);
    host_addr = a;
    #1;
    check(req, host_rdata, exp, what);
  endtask

  bit fin = 1'b0;

  initial begin
    for (int i = 0; i < 32; i++) begin
      phy_mem[i] = 16'h5A00 ^ (16'(i) * 16'h0111);
      exp_mem[i] = phy_mem[i];
    end
    repeat (5) @(negedge clk);
    check("R1", {29'd0, mdc, mdio_oe, mgmt_done}, 32'd0, "outputs in reset");
    rd_chk(CMD_A, 32'd0, "R1", "read data after reset");
    rd_chk(DIV_A, 32'd1, "R1", "divider after reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6", {31'd0, mdc}, 32'd0, "MDC idle low");

    bus_write(DIV_A, 32'd2); cur_div = 2;
    rd_chk(DIV_A, 32'd2, "R6", "divider readback");

    @(negedge clk);
    issue(2'b01, PHY_ID, 5'd5, 16'h1234);
    wait_done();
    issue(2'b10, PHY_ID, 5'd5, 16'h0000);   // written in the completion cycle
    wait_done();
    rd_chk(CMD_A, {16'd0, exp_mem[5]}, "R4", "read back after write");

    @(negedge clk);
    issue(2'b10, PHY_ID, 5'd9, 16'h0000);
    wait_done();
    rd_chk(CMD_A, {16'd0, exp_mem[9]}, "R4", "read of untouched register");

    @(negedge clk);
    issue(2'b10, 5'd7, 5'd2, 16'h0000);
    wait_done();
    rd_chk(CMD_A, 32'h0000_FFFF, "R5", "absent PHY");

    @(negedge clk);
    issue(2'b00, PHY_ID, 5'd1, 16'hAAAA);
    check("R8", {31'd0, mgmt_done}, 32'd1, "done after opcode 00");
    rd_chk(CMD_A, 32'h0000_FFFF, "R8", "read data kept after opcode 00");
    @(negedge clk);
    issue(2'b11, PHY_ID, 5'd1, 16'h5555);
    check("R8", {31'd0, mgmt_done}, 32'd1, "done after opcode 11");
    rd_chk(CMD_A, 32'h0000_FFFF, "R8", "read data kept after opcode 11");
    check("R8", {16'd0, phy_mem[1]}, {16'd0, exp_mem[1]}, "PHY untouched");

    @(negedge clk);
    bus_write(DIV_A, 32'd0); cur_div = 0;
    issue(2'b01, PHY_ID, 5'd1, 16'hBEEF);
    wait_done();
    issue(2'b10, PHY_ID, 5'd1, 16'h0000);
    wait_done();
    rd_chk(CMD_A, 32'h0000_BEEF, "R4", "read at fastest divider");

    @(negedge clk);
    bus_write(DIV_A, 32'd3); cur_div = 3;
    issue(2'b10, PHY_ID, 5'd5, 16'h0000);
    repeat (20) @(negedge clk);
    bus_write(CMD_A, {2'b00, 2'b01, PHY_ID, 5'd5, 2'b00, 16'h0000});
    bus_write(DIV_A, 32'd7);
    rd_chk(DIV_A, 32'd3, "R9", "divider write during frame");
    wait_done();
    rd_chk(CMD_A, {16'd0, exp_mem[5]}, "R9", "frame unchanged by late command");
    @(negedge clk);
    issue(2'b10, PHY_ID, 5'd5, 16'h0000);
    wait_done();
    rd_chk(CMD_A, 32'h0000_1234, "R9", "ignored write never reached PHY");

    repeat (10) @(negedge clk);
    fin = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule